// File: doc/BRIEF.md
# Virtual-Wire Event Interrupt Controller

This block turns two groups of 32 event lines, each line the current level of one virtual wire, into a single interrupt for a management processor. Every line has its own trigger type. The type is a 3-bit code assembled from one bit in each of three parallel type registers. A line can watch for both edges, for rising edges only, or for nothing. A detected edge on an enabled line sets a sticky status bit. Software clears that bit by writing a one to it.

Each group reduces its enabled, pending bits to one summary flag. The two summary flags sit at fixed positions of a top-level status word: bit 8 for group A and bit 22 for group B. The same word holds a latched cause bit at position 31 for a hardware reset of the link. A top-level enable word gates these three bits onto the interrupt output.

Software reaches the registers through a plain word-addressed register port. The port has an address, write data and a write strobe. Reads are combinational. The block does not decode the link packets that produce the wire levels.

Top module: `vw_event_irq_ctrl`

## Requirements
- R1: After reset every register reads zero and `irq` is low.
- R2: A line whose code {type2,type1,type0} is 3'b100 sets its status bit on a rising edge and also on a falling edge of the line, provided its enable bit is set. The status bit can be read one clock after the edge.
- R3: A line whose code is 3'b001 sets its status bit on a rising edge only. A falling edge leaves the bit clear.
- R4: Every code other than 3'b100 and 3'b001 disables the line, so no edge sets its status bit.
- R5: An edge on a line whose enable bit is clear does not set its status bit.
- R6: Writing the status register clears each bit written as one and leaves each bit written as zero unchanged.
- R7: If an edge and a clear of the same status bit occur in the same cycle, the bit ends up set.
- R8: Top-level status bit 8 reads as the OR of group A status AND group A enable, and bit 22 reads the same way for group B. Clearing the enables drops the summary while the group status is kept.
- R9: A high level on `link_reset_evt` latches top-level status bit 31. Writing a one to bit 31 of the top-level status clears it.
- R10: `irq` is the OR of the top-level status word ANDed with the top-level enable word. Only bits 8, 22 and 31 of the enable word are stored.
- R11: The word addresses are fixed. Top status is at 0x00 and top enable at 0x01. Group A uses 0x08 enable, 0x09 type0, 0x0A type1, 0x0B type2 and 0x0C status. Group B uses the same layout from 0x10 to 0x14. All other addresses read zero and ignore writes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_addr | input | 5 | Register word address |
| bus_wdata | input | 32 | Register write data |
| bus_we | input | 1 | Write strobe, one cycle per write |
| bus_rdata | output | 32 | Combinational read data for `bus_addr` |
| grp_a_lines | input | 32 | Group A wire levels |
| grp_b_lines | input | 32 | Group B wire levels |
| link_reset_evt | input | 1 | Hardware reset indication of the link |
| irq | output | 1 | Interrupt request |

## Verification
If the previous-value register or the trigger decode is wrong, it shows up as a status bit that is set or missing in the status read right after the edge clock. No delay hides it. A broken W1C or set-priority path shows up in the same read that follows the clearing write. A bad summary or gating term shows up at once on top-status bits 8 and 22 and on `irq`, because both are combinational from the stored bits. The bench therefore samples each of them one cycle after the cause.

// File: rtl/vw_irq_pkg.sv
package vw_irq_pkg;
  localparam logic [2:0] TRIG_RISE = 3'b001;
  localparam logic [2:0] TRIG_BOTH = 3'b100;

  localparam int unsigned OFS_ENABLE = 0;
  localparam int unsigned OFS_TYPE0  = 1;
  localparam int unsigned OFS_TYPE1  = 2;
  localparam int unsigned OFS_TYPE2  = 3;
  localparam int unsigned OFS_STATUS = 4;

  localparam int unsigned TOP_STATUS_ADDR = 0;
  localparam int unsigned TOP_ENABLE_ADDR = 1;
endpackage

// File: rtl/vw_edge_detect.sv
module vw_edge_detect
  import vw_irq_pkg::*;
#(
  parameter int unsigned W = 32
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] lines,
  input  logic [W-1:0] type0,
  input  logic [W-1:0] type1,
  input  logic [W-1:0] type2,
  output logic [W-1:0] hit
);
  logic [W-1:0] prev_q;
  logic [W-1:0] prev_d;
  logic [W-1:0] rise;
  logic [W-1:0] fall;

  always_comb begin
    prev_d = lines;
    rise   = lines & ~prev_q;
    fall   = ~lines & prev_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) prev_q <= '0;
    else        prev_q <= prev_d;
  end

  for (genvar i = 0; i < W; i++) begin : g_bit
    logic [2:0] code;
    assign code   = {type2[i], type1[i], type0[i]};
    assign hit[i] = (code == TRIG_BOTH) ? (rise[i] | fall[i]) :
                    (code == TRIG_RISE) ? rise[i] : 1'b0;

    // rising-only lines never report while the line sits low
    assert_rise_only_R3: assert property (@(posedge clk) disable iff (!rst_n)
      ((code == TRIG_RISE) && hit[i]) |-> lines[i]);
  end
endmodule

// File: rtl/vw_event_bank.sv
module vw_event_bank
  import vw_irq_pkg::*;
#(
  parameter int unsigned W      = 32,
  parameter int unsigned ADDR_W = 5,
  parameter int unsigned BASE   = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [W-1:0]      lines,
  input  logic [ADDR_W-1:0] addr,
  input  logic [W-1:0]      wdata,
  input  logic              we,
  output logic [W-1:0]      rdata,
  output logic              summary
);
  localparam logic [ADDR_W-1:0] A_EN = ADDR_W'(BASE + OFS_ENABLE);
  localparam logic [ADDR_W-1:0] A_T0 = ADDR_W'(BASE + OFS_TYPE0);
  localparam logic [ADDR_W-1:0] A_T1 = ADDR_W'(BASE + OFS_TYPE1);
  localparam logic [ADDR_W-1:0] A_T2 = ADDR_W'(BASE + OFS_TYPE2);
  localparam logic [ADDR_W-1:0] A_ST = ADDR_W'(BASE + OFS_STATUS);

  logic [W-1:0] en_q, en_d;
  logic [W-1:0] t0_q, t0_d;
  logic [W-1:0] t1_q, t1_d;
  logic [W-1:0] t2_q, t2_d;
  logic [W-1:0] st_q, st_d;
  logic [W-1:0] clr;
  logic [W-1:0] hit;

  vw_edge_detect #(.W(W)) u_edge (
    .clk   (clk),
    .rst_n (rst_n),
    .lines (lines),
    .type0 (t0_q),
    .type1 (t1_q),
    .type2 (t2_q),
    .hit   (hit)
  );

  always_comb begin
    en_d = (we && addr == A_EN) ? wdata : en_q;
    t0_d = (we && addr == A_T0) ? wdata : t0_q;
    t1_d = (we && addr == A_T1) ? wdata : t1_q;
    t2_d = (we && addr == A_T2) ? wdata : t2_q;
    clr  = (we && addr == A_ST) ? wdata : '0;
    // a fresh edge overrides a same-cycle clear
    st_d = (st_q & ~clr) | (hit & en_q);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_q <= '0;
      t0_q <= '0;
      t1_q <= '0;
      t2_q <= '0;
      st_q <= '0;
    end else begin
      en_q <= en_d;
      t0_q <= t0_d;
      t1_q <= t1_d;
      t2_q <= t2_d;
      st_q <= st_d;
    end
  end

  always_comb begin
    rdata = '0;
    case (addr)
      A_EN:    rdata = en_q;
      A_T0:    rdata = t0_q;
      A_T1:    rdata = t1_q;
      A_T2:    rdata = t2_q;
      A_ST:    rdata = st_q;
      default: rdata = '0;
    endcase
  end

  assign summary = |(st_q & en_q);

  assert_edge_latches_R2: assert property (@(posedge clk) disable iff (!rst_n)
    ((hit & en_q) != '0) |=> ((st_q & $past(hit & en_q)) == $past(hit & en_q)));

  assert_disabled_quiet_R5: assert property (@(posedge clk) disable iff (!rst_n)
    ((st_q & ~$past(st_q) & ~$past(en_q)) == '0));

  assert_w1c_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (we && addr == A_ST) |=> ((st_q & $past(wdata) & ~$past(hit)) == '0));
endmodule

// File: rtl/vw_top_status.sv
module vw_top_status
  import vw_irq_pkg::*;
#(
  parameter int unsigned W      = 32,
  parameter int unsigned ADDR_W = 5,
  parameter int unsigned A_BIT  = 8,
  parameter int unsigned B_BIT  = 22,
  parameter int unsigned HW_BIT = 31
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sum_a,
  input  logic              sum_b,
  input  logic              hw_evt,
  input  logic [ADDR_W-1:0] addr,
  input  logic [W-1:0]      wdata,
  input  logic              we,
  output logic [W-1:0]      rdata,
  output logic              irq
);
  localparam logic [ADDR_W-1:0] A_ST = ADDR_W'(TOP_STATUS_ADDR);
  localparam logic [ADDR_W-1:0] A_EN = ADDR_W'(TOP_ENABLE_ADDR);
  localparam logic [W-1:0] EN_MASK =
    (W'(1) << A_BIT) | (W'(1) << B_BIT) | (W'(1) << HW_BIT);

  logic         hw_q, hw_d;
  logic [W-1:0] en_q, en_d;
  logic [W-1:0] status;

  always_comb begin
    en_d = (we && addr == A_EN) ? (wdata & EN_MASK) : en_q;
    hw_d = hw_evt | (hw_q & ~(we && addr == A_ST && wdata[HW_BIT]));
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hw_q <= 1'b0;
      en_q <= '0;
    end else begin
      hw_q <= hw_d;
      en_q <= en_d;
    end
  end

  always_comb begin
    status         = '0;
    status[A_BIT]  = sum_a;
    status[B_BIT]  = sum_b;
    status[HW_BIT] = hw_q;
  end

  always_comb begin
    case (addr)
      A_ST:    rdata = status;
      A_EN:    rdata = en_q;
      default: rdata = '0;
    endcase
  end

  assign irq = |(status & en_q);

  assert_hw_cause_R9: assert property (@(posedge clk) disable iff (!rst_n)
    hw_evt |=> status[HW_BIT]);

  assert_irq_gated_R10: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> (en_q != '0));
endmodule

// File: rtl/vw_event_irq_ctrl.sv
module vw_event_irq_ctrl
  import vw_irq_pkg::*;
#(
  parameter int unsigned DATA_W = 32,
  parameter int unsigned ADDR_W = 5,
  parameter int unsigned BASE_A = 8,
  parameter int unsigned BASE_B = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  input  logic              bus_we,
  output logic [DATA_W-1:0] bus_rdata,
  input  logic [DATA_W-1:0] grp_a_lines,
  input  logic [DATA_W-1:0] grp_b_lines,
  input  logic              link_reset_evt,
  output logic              irq
);
  logic [DATA_W-1:0] rd_a, rd_b, rd_top;
  logic              sum_a, sum_b;

  vw_event_bank #(.W(DATA_W), .ADDR_W(ADDR_W), .BASE(BASE_A)) u_bank_a (
    .clk     (clk),
    .rst_n   (rst_n),
    .lines   (grp_a_lines),
    .addr    (bus_addr),
    .wdata   (bus_wdata),
    .we      (bus_we),
    .rdata   (rd_a),
    .summary (sum_a)
  );

  vw_event_bank #(.W(DATA_W), .ADDR_W(ADDR_W), .BASE(BASE_B)) u_bank_b (
    .clk     (clk),
    .rst_n   (rst_n),
    .lines   (grp_b_lines),
    .addr    (bus_addr),
    .wdata   (bus_wdata),
    .we      (bus_we),
    .rdata   (rd_b),
    .summary (sum_b)
  );

  vw_top_status #(.W(DATA_W), .ADDR_W(ADDR_W)) u_top (
    .clk    (clk),
    .rst_n  (rst_n),
    .sum_a  (sum_a),
    .sum_b  (sum_b),
    .hw_evt (link_reset_evt),
    .addr   (bus_addr),
    .wdata  (bus_wdata),
    .we     (bus_we),
    .rdata  (rd_top),
    .irq    (irq)
  );

  // decoders are disjoint, so OR-combining is a clean mux
  assign bus_rdata = rd_a | rd_b | rd_top;
endmodule

// File: tb/sim_vw_event_irq_ctrl.sv
module sim_vw_event_irq_ctrl;
  logic        clk = 1'b0;
  logic        rst_n;
  logic [4:0]  bus_addr;
  logic [31:0] bus_wdata;
  logic        bus_we;
  logic [31:0] bus_rdata;
  logic [31:0] grp_a_lines;
  logic [31:0] grp_b_lines;
  logic        link_reset_evt;
  logic        irq;

  int n_checks = 0;
  int n_fail   = 0;

  localparam logic [4:0] TOP_ST = 5'h00;
  localparam logic [4:0] TOP_EN = 5'h01;
  localparam logic [4:0] BA     = 5'h08;
  localparam logic [4:0] BB     = 5'h10;

  // {group, bit[4:0], code[2:0], enable, falling, expect}
  localparam int NV = 14;
  localparam logic [11:0] VEC [NV] = '{
    {1'b0, 5'd8,  3'b100, 1'b1, 1'b0, 1'b1},
    {1'b0, 5'd8,  3'b100, 1'b1, 1'b1, 1'b1},
    {1'b0, 5'd6,  3'b100, 1'b1, 1'b1, 1'b1},
    {1'b0, 5'd5,  3'b100, 1'b1, 1'b0, 1'b1},
    {1'b1, 5'd0,  3'b001, 1'b1, 1'b0, 1'b1},
    {1'b1, 5'd0,  3'b001, 1'b1, 1'b1, 1'b0},
    {1'b0, 5'd3,  3'b000, 1'b1, 1'b0, 1'b0},
    {1'b0, 5'd31, 3'b010, 1'b1, 1'b0, 1'b0},
    {1'b1, 5'd17, 3'b011, 1'b1, 1'b1, 1'b0},
    {1'b1, 5'd9,  3'b111, 1'b1, 1'b0, 1'b0},
    {1'b0, 5'd12, 3'b100, 1'b0, 1'b0, 1'b0},
    {1'b1, 5'd2,  3'b001, 1'b0, 1'b0, 1'b0},
    {1'b1, 5'd30, 3'b101, 1'b1, 1'b0, 1'b0},
    {1'b0, 5'd20, 3'b110, 1'b1, 1'b1, 1'b0}
  };

  vw_event_irq_ctrl u0 (
    .clk            (clk),
    .rst_n          (rst_n),
    .bus_addr       (bus_addr),
    .bus_wdata      (bus_wdata),
    .bus_we         (bus_we),
    .bus_rdata      (bus_rdata),
    .grp_a_lines    (grp_a_lines),
    .grp_b_lines    (grp_b_lines),
    .link_reset_evt (link_reset_evt),
    .irq            (irq)
  );

  always #4 clk = ~clk;

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [4:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_addr = a; bus_wdata = d; bus_we = 1'b1;
    @(negedge clk);
    bus_we = 1'b0;
  endtask

  task automatic rd(input logic [4:0] a, output logic [31:0] d);
    @(negedge clk);
    bus_addr = a; bus_we = 1'b0;
    #1 d = bus_rdata;
  endtask

  task automatic set_line(input logic grp, input int b, input logic v);
    @(negedge clk);
    if (grp) grp_b_lines[b] = v; else grp_a_lines[b] = v;
    @(negedge clk);
  endtask

  function automatic string vtag(input logic [11:0] v);
    if (!v[2]) return "R5";
    if (v[5:3] == 3'b100) return "R2";
    if (v[5:3] == 3'b001) return "R3";
    return "R4";
  endfunction

  initial begin
    #(8 * 200000);
    n_fail++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
    $finish;
  end

  initial begin
    logic [31:0] d;
    rst_n = 1'b0; bus_addr = '0; bus_wdata = '0; bus_we = 1'b0;
    grp_a_lines = '0; grp_b_lines = '0; link_reset_evt = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R1: reset state
    for (int a = 0; a < 32; a++) begin
      rd(5'(a), d);
      check("R1 reset read", d, 32'h0);
    end
    check("R1 irq after reset", {31'b0, irq}, 32'h0);

    // R11: type readback, unmapped ignore
    wr(BA + 5'd1, 32'hA5A5_0F0F);
    rd(BA + 5'd1, d);
    check("R11 type0 readback", d, 32'hA5A5_0F0F);
    wr(BB + 5'd3, 32'h1234_5678);
    rd(BB + 5'd3, d);
    check("R11 group B type2 readback", d, 32'h1234_5678);
    wr(5'h1F, 32'hFFFF_FFFF);
    rd(5'h1F, d);
    check("R11 unmapped read", d, 32'h0);
    wr(5'h05, 32'hFFFF_FFFF);
    rd(5'h05, d);
    check("R11 unmapped read 0x05", d, 32'h0);
    wr(TOP_EN, 32'hFFFF_FFFF);
    rd(TOP_EN, d);
    check("R10 top enable stored bits", d, 32'h8040_0100);
    wr(TOP_EN, 32'h0);

    // vector table
    for (int k = 0; k < NV; k++) begin
      logic [11:0] v;
      logic [4:0]  base;
      int          b;
      v    = VEC[k];
      b    = int'(v[10:6]);
      base = v[11] ? BB : BA;
      wr(base + 5'd1, {31'b0, v[3]} << b);
      wr(base + 5'd2, {31'b0, v[4]} << b);
      wr(base + 5'd3, {31'b0, v[5]} << b);
      wr(base + 5'd0, {31'b0, v[2]} << b);
      wr(base + 5'd4, 32'hFFFF_FFFF);
      if (v[1]) begin
        set_line(v[11], b, 1'b1);
        wr(base + 5'd4, 32'hFFFF_FFFF);
      end
      set_line(v[11], b, !v[1]);
      rd(base + 5'd4, d);
      check($sformatf("%s vector %0d status", vtag(v), k), d, {31'b0, v[0]} << b);
      set_line(v[11], b, 1'b0);
      wr(base + 5'd4, 32'hFFFF_FFFF);
    end

    // R7: edge and clear in same cycle on group A bit 8
    wr(BA + 5'd1, 32'h0); wr(BA + 5'd2, 32'h0);
    wr(BA + 5'd3, 32'h0000_0100);
    wr(BA + 5'd0, 32'h0000_0100);
    @(negedge clk);
    grp_a_lines[8] = 1'b1;
    bus_addr = BA + 5'd4; bus_wdata = 32'h0000_0100; bus_we = 1'b1;
    @(negedge clk);
    bus_we = 1'b0;
    rd(BA + 5'd4, d);
    check("R7 set beats clear", d, 32'h0000_0100);

    // R6: zeros keep, ones clear
    wr(BA + 5'd4, 32'h0);
    rd(BA + 5'd4, d);
    check("R6 zero write keeps", d, 32'h0000_0100);

    // R8: summary on top status bit 8
    rd(TOP_ST, d);
    check("R8 group A summary", d, 32'h0000_0100);
    check("R10 irq low with top enable zero", {31'b0, irq}, 32'h0);
    wr(TOP_EN, 32'h0000_0100);
    #1 check("R10 irq raised by bit 8", {31'b0, irq}, 32'h1);
    wr(BA + 5'd0, 32'h0);
    rd(TOP_ST, d);
    check("R8 summary drops with enable", d, 32'h0);
    rd(BA + 5'd4, d);
    check("R8 status kept", d, 32'h0000_0100);
    check("R10 irq low after enable cleared", {31'b0, irq}, 32'h0);
    wr(BA + 5'd4, 32'h0000_0100);
    rd(BA + 5'd4, d);
    check("R6 one write clears", d, 32'h0);
    set_line(1'b0, 8, 1'b0);
    wr(BA + 5'd4, 32'hFFFF_FFFF);

    // R8: group B on bit 22
    wr(BB + 5'd1, 32'h1); wr(BB + 5'd2, 32'h0); wr(BB + 5'd3, 32'h0);
    wr(BB + 5'd0, 32'h1);
    set_line(1'b1, 0, 1'b1);
    rd(TOP_ST, d);
    check("R8 group B summary", d, 32'h0040_0000);
    wr(TOP_EN, 32'h0040_0000);
    #1 check("R10 irq raised by bit 22", {31'b0, irq}, 32'h1);
    wr(BB + 5'd4, 32'h1);
    rd(TOP_ST, d);
    check("R6 group B cleared", d, 32'h0);
    check("R10 irq low after clear", {31'b0, irq}, 32'h0);

    // R9: hardware reset cause
    @(negedge clk);
    link_reset_evt = 1'b1;
    @(negedge clk);
    link_reset_evt = 1'b0;
    rd(TOP_ST, d);
    check("R9 cause latched", d, 32'h8000_0000);
    check("R10 irq masked for bit 31", {31'b0, irq}, 32'h0);
    wr(TOP_EN, 32'h8000_0000);
    #1 check("R10 irq raised by bit 31", {31'b0, irq}, 32'h1);
    wr(TOP_ST, 32'h7FFF_FFFF);
    rd(TOP_ST, d);
    check("R9 zero bit 31 keeps cause", d, 32'h8000_0000);
    wr(TOP_ST, 32'h8000_0000);
    rd(TOP_ST, d);
    check("R9 cause cleared", d, 32'h0);
    check("R10 irq low after cause clear", {31'b0, irq}, 32'h0);

    $display("TB_RESULT checks=%0d failures=%0d", n_checks, n_fail);
    $finish;
  end
endmodule